// File: doc/BRIEF.md
# DMA Channel Interrupt and Control Register Block

This block holds the shared control and status words of a sixteen-channel peripheral DMA engine. The channel engines report each finished transfer on a completion event input and each failure on an error event input, with a cause qualifier that tells a bus error from a termination. The block latches these events as per-channel flags. It combines them with per-channel enables into one interrupt line per channel. It also drives per-channel reset strobes and freeze levels, plus two burst mode enables, towards the channel engines.

Software reaches four 32-bit words over a simple register bus. Each word has four addresses: a plain write, a set alias, a clear alias and a toggle alias. A driver can therefore change single bits without a read-modify-write sequence. This matters because hardware events can update the same word at any moment.

Top module: `dmairq_regs`

## Requirements
- R1: After reset the main control word reads 0x3000_0000, with both burst enables on. The completion, error and channel control words read 0. All per-channel outputs are 0.
- R2: Address bits [5:4] select the word: 0 main control, 1 completion, 2 error, 3 channel control. Bits [3:2] select the access: 0 plain write, 1 set, 2 clear, 3 toggle. Any address with a bit above bit 5 set reads 0, and a write to it changes nothing.
- R3: A set access ORs the data into the word, a clear access removes the data bits, and a toggle access inverts them. A plain write replaces the word. Bits outside the mask keep their value.
- R4: Software may change only bits 28 and 29 of the main control word, and only bits [15:0] of the error word. All bits of the completion and channel control words are writable.
- R5: A completion event on channel n sets bit n of the completion word. Bit 16+n of that word is the channel's interrupt enable.
- R6: An error event on channel n sets bit n of the error word and loads bit 16+n with the cause input (1 = bus error, 0 = termination). The cause bits change only on error events.
- R7: When an event and a software access change the same flag bit in the same cycle, the event wins and the bit ends set.
- R8: irq_o[n] is high exactly when (completion bit n AND completion bit 16+n) OR error bit n.
- R9: Writing 1 to channel control bit 16+n drives chan_reset_o[n] high for exactly the one cycle after the write. The bit then reads back 0.
- R10: chan_freeze_o[n] follows channel control bit n. burst_en_o follows main control bit 28 and burst8_en_o follows bit 29.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for the access |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Read data of the addressed word |
| done_evt | input | 16 | Per-channel completion event, one cycle per event |
| err_evt | input | 16 | Per-channel error event, one cycle per event |
| err_is_bus | input | 16 | Cause qualifying err_evt: 1 bus error, 0 termination |
| irq_o | output | 16 | Per-channel interrupt line |
| chan_reset_o | output | 16 | Per-channel one-cycle reset strobe |
| chan_freeze_o | output | 16 | Per-channel freeze level |
| burst_en_o | output | 1 | Burst mode enable |
| burst8_en_o | output | 1 | Eight-beat burst enable |

## Verification
The assertions check several rules on every cycle. An event flag is always set in the cycle after its event, whatever software did in the same cycle. A cause bit loads only with an error and otherwise holds. A pending error flag always raises its channel's interrupt. A reset strobe never lasts two cycles without a new write. The burst enables move only on writes to the main word. The alias arithmetic, the writable-bit masks, the address decode, the enable gating of completion interrupts and the exact cycle of each reset strobe can only be shown by the bench's scenarios, which compare readback and output values against hand-computed results.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned HI_OFS = 16;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_SET    = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_TOGGLE = 2'd3
  } alias_op_e;

  typedef enum logic [1:0] {
    W_MAIN  = 2'd0,
    W_DONE  = 2'd1,
    W_ERR   = 2'd2,
    W_CHCTL = 2'd3
  } word_sel_e;

  // Applies one software access to a word; only bits in wmask may move.
  function automatic logic [WORD_W-1:0] alias_apply(
      input logic [WORD_W-1:0] cur,
      input alias_op_e         op,
      input logic [WORD_W-1:0] val,
      input logic [WORD_W-1:0] wmask);
    logic [WORD_W-1:0] r;
    case (op)
      OP_WRITE: r = val;
      OP_SET:   r = cur | val;
      OP_CLEAR: r = cur & ~val;
      default:  r = cur ^ val;
    endcase
    return (r & wmask) | (cur & ~wmask);
  endfunction

  // Interrupt of one channel from its three contributing bits.
  function automatic logic irq_bit(input logic done_flag, input logic done_en,
                                   input logic err_flag);
    return (done_flag & done_en) | err_flag;
  endfunction

endpackage

// File: rtl/dmairq_decode.sv
module dmairq_decode
  import dmairq_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  output logic [3:0]    wr_en,
  output alias_op_e     op,
  output word_sel_e     rd_sel,
  output logic          rd_valid
);

  localparam int unsigned WSEL_LO = 4;
  localparam int unsigned OP_LO   = 2;
  localparam int unsigned TOP_LO  = 6;

  logic in_range;

  assign in_range = (bus_addr >> TOP_LO) == '0;
  assign op       = alias_op_e'(bus_addr[OP_LO +: 2]);
  assign rd_sel   = word_sel_e'(bus_addr[WSEL_LO +: 2]);
  assign rd_valid = in_range;

  for (genvar w = 0; w < 4; w++) begin : g_wen
    assign wr_en[w] = bus_sel & bus_wr & in_range &
                      (bus_addr[WSEL_LO +: 2] == 2'(w));
  end

endmodule

// File: rtl/dmairq_alias_reg.sv
module dmairq_alias_reg
  import dmairq_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_VAL = '0,
  parameter logic [WORD_W-1:0] WMASK     = '1,
  parameter logic [WORD_W-1:0] SCLR_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  alias_op_e         op,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] hw_mask,
  input  logic [WORD_W-1:0] hw_val,
  output logic [WORD_W-1:0] q
);

  logic [WORD_W-1:0] base;
  logic [WORD_W-1:0] sw_next;
  logic [WORD_W-1:0] nxt;

  always_comb begin
    // self-clearing bits drop after one cycle, before software is applied
    base    = q & ~SCLR_MASK;
    sw_next = wr_en ? alias_apply(base, op, wdata, WMASK) : base;
    // hardware updates are applied last so they take precedence
    nxt     = (sw_next & ~hw_mask) | (hw_val & hw_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RESET_VAL;
    else        q <= nxt;
  end

endmodule

// File: rtl/dmairq_irq_merge.sv
module dmairq_irq_merge
  import dmairq_pkg::*;
#(
  parameter int unsigned NCH = 16
) (
  input  logic [WORD_W-1:0] done_q,
  input  logic [WORD_W-1:0] err_q,
  output logic [NCH-1:0]    irq
);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign irq[n] = irq_bit(done_q[n], done_q[HI_OFS+n], err_q[n]);
  end

endmodule

// File: rtl/dmairq_regs.sv
module dmairq_regs
  import dmairq_pkg::*;
#(
  parameter int unsigned NCH = 16,
  parameter int unsigned AW  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NCH-1:0]   done_evt,
  input  logic [NCH-1:0]   err_evt,
  input  logic [NCH-1:0]   err_is_bus,
  output logic [NCH-1:0]   irq_o,
  output logic [NCH-1:0]   chan_reset_o,
  output logic [NCH-1:0]   chan_freeze_o,
  output logic             burst_en_o,
  output logic             burst8_en_o
);

  localparam int unsigned BURST_BIT  = 28;
  localparam int unsigned BURST8_BIT = 29;
  localparam logic [WORD_W-1:0] LOW_MASK   = WORD_W'((64'd1 << NCH) - 64'd1);
  localparam logic [WORD_W-1:0] HIGH_MASK  = LOW_MASK << HI_OFS;
  localparam logic [WORD_W-1:0] MAIN_BITS  =
      (WORD_W'(1) << BURST_BIT) | (WORD_W'(1) << BURST8_BIT);

  logic [3:0]        wr_en;
  alias_op_e         op;
  word_sel_e         rd_sel;
  logic              rd_valid;

  logic [WORD_W-1:0] main_q;
  logic [WORD_W-1:0] done_q;
  logic [WORD_W-1:0] err_q;
  logic [WORD_W-1:0] chctl_q;

  logic [WORD_W-1:0] done_ev_w;
  logic [WORD_W-1:0] err_ev_w;
  logic [WORD_W-1:0] err_bus_w;
  logic [WORD_W-1:0] done_hw_mask;
  logic [WORD_W-1:0] err_hw_mask;
  logic [WORD_W-1:0] err_hw_val;

  // named write strobes, used by the checker
  logic wr_main;
  logic wr_chctl;

  assign done_ev_w    = WORD_W'(done_evt);
  assign err_ev_w     = WORD_W'(err_evt);
  assign err_bus_w    = WORD_W'(err_evt & err_is_bus);
  assign done_hw_mask = done_ev_w;
  assign err_hw_mask  = err_ev_w | (err_ev_w << HI_OFS);
  assign err_hw_val   = err_ev_w | (err_bus_w << HI_OFS);
  assign wr_main      = wr_en[W_MAIN];
  assign wr_chctl     = wr_en[W_CHCTL];

  dmairq_decode #(.AW(AW)) u_dec (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wr_en    (wr_en),
    .op       (op),
    .rd_sel   (rd_sel),
    .rd_valid (rd_valid)
  );

  dmairq_alias_reg #(
    .RESET_VAL (MAIN_BITS),
    .WMASK     (MAIN_BITS),
    .SCLR_MASK ('0)
  ) u_main (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en[W_MAIN]), .op (op),
    .wdata (bus_wdata), .hw_mask ('0), .hw_val ('0), .q (main_q)
  );

  dmairq_alias_reg #(
    .RESET_VAL ('0),
    .WMASK     (LOW_MASK | HIGH_MASK),
    .SCLR_MASK ('0)
  ) u_done (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en[W_DONE]), .op (op),
    .wdata (bus_wdata), .hw_mask (done_hw_mask), .hw_val (done_hw_mask),
    .q (done_q)
  );

  dmairq_alias_reg #(
    .RESET_VAL ('0),
    .WMASK     (LOW_MASK),
    .SCLR_MASK ('0)
  ) u_err (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en[W_ERR]), .op (op),
    .wdata (bus_wdata), .hw_mask (err_hw_mask), .hw_val (err_hw_val),
    .q (err_q)
  );

  dmairq_alias_reg #(
    .RESET_VAL ('0),
    .WMASK     (LOW_MASK | HIGH_MASK),
    .SCLR_MASK (HIGH_MASK)
  ) u_chctl (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en[W_CHCTL]), .op (op),
    .wdata (bus_wdata), .hw_mask ('0), .hw_val ('0), .q (chctl_q)
  );

  dmairq_irq_merge #(.NCH(NCH)) u_irq (
    .done_q (done_q),
    .err_q  (err_q),
    .irq    (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_valid) begin
      case (rd_sel)
        W_MAIN:  bus_rdata = main_q;
        W_DONE:  bus_rdata = done_q;
        W_ERR:   bus_rdata = err_q;
        default: bus_rdata = chctl_q;
      endcase
    end
  end

  assign chan_reset_o  = chctl_q[HI_OFS +: NCH];
  assign chan_freeze_o = chctl_q[0 +: NCH];
  assign burst_en_o    = main_q[BURST_BIT];
  assign burst8_en_o   = main_q[BURST8_BIT];

endmodule

// File: rtl/dmairq_regs_chk.sv
module dmairq_regs_chk #(
  parameter int unsigned NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] done_evt,
  input logic [NCH-1:0] err_evt,
  input logic [NCH-1:0] err_is_bus,
  input logic [NCH-1:0] irq_o,
  input logic [NCH-1:0] chan_reset_o,
  input logic           burst_en_o,
  input logic           burst8_en_o,
  input logic [31:0]    done_q,
  input logic [31:0]    err_q,
  input logic           wr_main,
  input logic           wr_chctl
);

  // R5 / R7: a completion event always leaves its flag set
  p_done_evt_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt != '0) |=> ((done_q[NCH-1:0] & $past(done_evt)) == $past(done_evt)));

  // R6 / R7: an error event always leaves its flag set
  p_err_evt_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt != '0) |=> ((err_q[NCH-1:0] & $past(err_evt)) == $past(err_evt)));

  // R6: the cause bit takes the qualifier of the event
  p_cause_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt != '0) |=>
      ((err_q[16 +: NCH] & $past(err_evt)) == ($past(err_evt) & $past(err_is_bus))));

  // R6: without error events the cause half holds
  p_cause_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt == '0) |=> $stable(err_q[31:16]));

  // R8: a pending error flag always raises its interrupt
  p_err_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_q[NCH-1:0] & ~irq_o) == '0));

  // R9: a reset strobe never stays high two cycles without a new write
  p_rst_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_chctl |=> ((chan_reset_o & $past(chan_reset_o)) == '0));

  // R4 / R10: burst enables move only on main control writes
  p_burst_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_main |=> $stable({burst8_en_o, burst_en_o}));

endmodule

bind dmairq_regs dmairq_regs_chk #(.NCH(NCH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .done_evt     (done_evt),
  .err_evt      (err_evt),
  .err_is_bus   (err_is_bus),
  .irq_o        (irq_o),
  .chan_reset_o (chan_reset_o),
  .burst_en_o   (burst_en_o),
  .burst8_en_o  (burst8_en_o),
  .done_q       (done_q),
  .err_q        (err_q),
  .wr_main      (wr_main),
  .wr_chctl     (wr_chctl)
);

// File: tb/dmairq_regs_tb.sv
module dmairq_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] done_evt = '0;
  logic [15:0] err_evt = '0;
  logic [15:0] err_is_bus = '0;
  logic [15:0] irq_o;
  logic [15:0] chan_reset_o;
  logic [15:0] chan_freeze_o;
  logic        burst_en_o;
  logic        burst8_en_o;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  dmairq_regs u_dut (
    .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_wr (bus_wr),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .done_evt (done_evt), .err_evt (err_evt), .err_is_bus (err_is_bus),
    .irq_o (irq_o), .chan_reset_o (chan_reset_o), .chan_freeze_o (chan_freeze_o),
    .burst_en_o (burst_en_o), .burst8_en_o (burst8_en_o)
  );

  typedef struct packed {
    logic [7:0]  waddr;
    logic [31:0] wdata;
    logic [7:0]  raddr;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{8'h10, 32'h0005_0005, 8'h10, 32'h0005_0005},  // R3 plain write
    '{8'h14, 32'h0000_0002, 8'h10, 32'h0005_0007},  // R3 set
    '{8'h18, 32'h0004_0001, 8'h10, 32'h0001_0006},  // R3 clear
    '{8'h1C, 32'h0003_0003, 8'h10, 32'h0002_0005},  // R3 toggle
    '{8'h08, 32'h1000_0000, 8'h00, 32'h2000_0000},  // R3 clear main
    '{8'h04, 32'hFFFF_FFFF, 8'h00, 32'h3000_0000},  // R4 main mask
    '{8'h00, 32'h0000_0000, 8'h00, 32'h0000_0000},
    '{8'h34, 32'h0000_00F0, 8'h30, 32'h0000_00F0},
    '{8'h3C, 32'h0000_0FF0, 8'h30, 32'h0000_0F00},
    '{8'h20, 32'hFFFF_FFFF, 8'h20, 32'h0000_FFFF},  // R4 err mask
    '{8'h28, 32'h0000_FFFF, 8'h20, 32'h0000_0000},
    '{8'h44, 32'h1234_5678, 8'h44, 32'h0000_0000}   // R2 out of range
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic events(input logic [15:0] de, input logic [15:0] ee,
                        input logic [15:0] eb);
    @(negedge clk);
    done_evt = de; err_evt = ee; err_is_bus = eb;
    @(negedge clk);
    done_evt = '0; err_evt = '0; err_is_bus = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    bus_read(8'h00, rd); chk("R1 main", rd, 32'h3000_0000);
    bus_read(8'h10, rd); chk("R1 done", rd, 32'h0);
    bus_read(8'h20, rd); chk("R1 err", rd, 32'h0);
    bus_read(8'h30, rd); chk("R1 chctl", rd, 32'h0);
    chk("R1 outputs", {irq_o, chan_reset_o}, 32'h0);
    chk("R1 burst", {30'h0, burst8_en_o, burst_en_o}, 32'h3);

    // R2 R3 R4 table
    for (int i = 0; i < NVEC; i++) begin
      bus_write(VEC[i].waddr, VEC[i].wdata);
      bus_read(VEC[i].raddr, rd);
      chk($sformatf("R2/R3/R4 vec%0d", i), rd, VEC[i].exp);
    end

    // R10 freeze and burst levels
    chk("R10 freeze", {16'h0, chan_freeze_o}, 32'h0000_0F00);
    chk("R10 burst", {30'h0, burst8_en_o, burst_en_o}, 32'h0);
    bus_write(8'h04, 32'h2000_0000);
    chk("R10 burst8", {30'h0, burst8_en_o, burst_en_o}, 32'h2);

    // R8: flags 0,2 set, only ch1 enabled -> no interrupt
    chk("R8 gated", {16'h0, irq_o}, 32'h0);
    // R5 completion event ch1
    events(16'h0002, 16'h0, 16'h0);
    bus_read(8'h10, rd); chk("R5 done evt", rd, 32'h0002_0007);
    chk("R8 done irq", {16'h0, irq_o}, 32'h0000_0002);

    // R6 errors: ch4 bus error, ch5 termination
    events(16'h0, 16'h0030, 16'h0010);
    bus_read(8'h20, rd); chk("R6 err evt", rd, 32'h0010_0030);
    chk("R8 err irq", {16'h0, irq_o}, 32'h0000_0032);
    bus_write(8'h28, 32'h0000_0030);
    bus_read(8'h20, rd); chk("R6 cause kept", rd, 32'h0010_0000);
    chk("R8 err cleared", {16'h0, irq_o}, 32'h0000_0002);
    bus_write(8'h2C, 32'h0010_0000);
    bus_read(8'h20, rd); chk("R6 cause not writable", rd, 32'h0010_0000);
    events(16'h0, 16'h0010, 16'h0000);
    bus_read(8'h20, rd); chk("R6 cause termination", rd, 32'h0000_0010);

    // R7 collision: clear bits 0,1 while event on ch1
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h3;
    done_evt = 16'h0002;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; done_evt = '0;
    bus_read(8'h10, rd); chk("R7 event wins", rd, 32'h0002_0006);

    // R9 reset strobe on ch3
    bus_write(8'h34, 32'h0008_0000);
    #1;
    chk("R9 strobe high", {16'h0, chan_reset_o}, 32'h0000_0008);
    @(negedge clk);
    #1;
    chk("R9 strobe low", {16'h0, chan_reset_o}, 32'h0);
    bus_read(8'h30, rd); chk("R9 readback", rd, 32'h0000_0F00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule